// File: doc/BRIEF.md
# Four-Rail Supply Sequencer

This controller brings up a group of supply rails for a bank of FPGAs in a fixed order and watches them while they run. Software sets an enable bit through a byte-wide register bus. The sequencer then switches on rail 0 and waits for that rail's power-good input. It switches on rail 1 only after that, and so on through the last rail. Once every rail reports good, the sequencer holds them on and watches for any rail that drops out.

A rail that does not report good within a bounded step time is a fault. A rail that was already good and then loses power-good is also a fault. On a fault, every rail is switched off and the alarm is raised. The failing rail is recorded as a one-hot bit, and that record holds until software writes the enable bit low.

Each disable starts a discharge lockout. During the lockout the rails cannot be switched on again. An enable written during the lockout is held and acted on when the lockout ends. This keeps the sequencer from stalling while it waits for power-goods on rails that never finished discharging.

Top module: `pwr_seq`

## Requirements
- R1: After reset, every rail enable output is 0 and the alarm output is 0. The control, status and failure registers read 0x00, and the identity register reads 0x03.
- R2: The register bus decodes the low address nibble as follows:
  - 0x0 is the read-only identity register and reads 0x03.
  - 0x6 is control. Bit 0 is the enable, and the written byte reads back unchanged.
  - 0xA is status. Bits 3:0 are the raw power-good inputs, one bit per rail in rail order, and bit 4 is the alarm.
  - 0xB is the failure register. Bits 3:0 are a one-hot mark of the failing rail.
  - Every other address reads 0x00. Writes to any address other than control have no effect.
- R3: Turn-on is ordered. Rail i+1 is never switched on before the power-good of rail i is high. The enabled rails always form a contiguous group starting at rail 0. With all power-goods following their enables, all four rails end up on and status reads 0x0F.
- R4: If the rail being brought up does not report good, it stays enabled for exactly STEP_CYCLES clock cycles. After that a fault is taken and the failure register marks that rail.
- R5: On a fault, all rail enables go low on the edge that takes the fault. From that edge the alarm output and status bit 4 are 1, and the failure register holds exactly one bit.
- R6: A rail that was already good and loses power-good causes a fault. This applies while all rails are on and while a later rail is still ramping. If several rails drop together, only the lowest-numbered one is marked. A dropout takes priority over a step timeout.
- R7: The fault is sticky. Writing the enable bit high again does not clear the alarm or the failure register and switches no rail on. Writing the enable bit low clears both on that write's edge.
- R8: Writing the enable bit low switches every rail off on that write's clock edge.
- R9: Each disable, whether from a running state or from a fault, starts a lockout of DISCH_CYCLES cycles. An enable written on the edge right after the disable is held. Rail 0 then switches on exactly DISCH_CYCLES+2 edges after the disable edge. An enable written after the lockout has ended switches rail 0 on at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the register bus |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| pgood | input | N_RAILS | Power-good from each rail |
| rail_en | output | N_RAILS | Enable to each rail regulator |
| alarm | output | 1 | Latched fault indication |

## Verification
The hardest situation to reach from the ports is a dropout on an earlier rail while a later rail is still waiting for its power-good. That situation must be told apart from the later rail's own step timeout. The bench models each rail's power-good as following its enable one cycle later. A block mask holds one rail's good low so that ramping stalls on it. A drop mask pulls already-good rails down at a chosen moment. A second hard case is an enable that lands inside the discharge lockout. The bench writes the enable on the edge right after the disable and times the first rail's return by the edge count.

// File: rtl/pwr_seq.sv
module pwr_seq #(
  parameter int N_RAILS      = 4,
  parameter int STEP_CYCLES  = 12_500_000,
  parameter int DISCH_CYCLES = 62_500_000,
  parameter logic [7:0] VERSION = 8'h03
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [3:0]         reg_addr,
  input  logic [7:0]         reg_wdata,
  output logic [7:0]         reg_rdata,
  input  logic [N_RAILS-1:0] pgood,
  output logic [N_RAILS-1:0] rail_en,
  output logic               alarm
);
  localparam int CNT_MAX = (STEP_CYCLES > DISCH_CYCLES) ? STEP_CYCLES : DISCH_CYCLES;
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int IW = (N_RAILS > 1) ? $clog2(N_RAILS) : 1;
  localparam logic [3:0] A_ID   = 4'h0;
  localparam logic [3:0] A_CTRL = 4'h6;
  localparam logic [3:0] A_STAT = 4'hA;
  localparam logic [3:0] A_FAIL = 4'hB;
  localparam logic [N_RAILS-1:0] ALL = '1;

  typedef enum logic [2:0] {S_OFF, S_RAMP, S_ON, S_FAULT, S_DISCH} st_t;

  st_t               st;
  logic [IW-1:0]     idx;
  logic [CW-1:0]     cnt;
  logic [7:0]        ctrl_q;
  logic              alarm_q;
  logic [N_RAILS-1:0] fail_q;

  logic               ctrl_en;
  logic               ctl_wr;
  logic               clr_wr;
  logic [N_RAILS-1:0] up_to, below, settled, dropped, trip_vec;
  logic               step_to, trip;

  assign ctrl_en = ctrl_q[0];
  assign ctl_wr  = reg_wr && (reg_addr == A_CTRL);
  assign clr_wr  = ctl_wr && !reg_wdata[0];
  assign alarm   = alarm_q;

  always_comb begin
    for (int j = 0; j < N_RAILS; j++) begin
      up_to[j] = (IW'(j) <= idx);
      below[j] = (IW'(j) <  idx);
    end
  end

  assign settled  = (st == S_ON) ? ALL : (st == S_RAMP) ? below : '0;
  assign dropped  = settled & ~pgood;
  assign step_to  = (st == S_RAMP) && !pgood[idx] && (cnt == CW'(STEP_CYCLES - 1));
  assign trip_vec = (|dropped) ? (dropped & (~dropped + 1'b1))
                  : step_to    ? (N_RAILS'(1) << idx) : '0;
  assign trip     = ctrl_en && ((st == S_RAMP) || (st == S_ON)) && (|trip_vec);

  assign rail_en = !ctrl_en ? '0 : (st == S_RAMP) ? up_to : (st == S_ON) ? ALL : '0;

  always_comb begin
    reg_rdata = 8'h00;
    case (reg_addr)
      A_ID:   reg_rdata = VERSION;
      A_CTRL: reg_rdata = ctrl_q;
      A_STAT: begin
        reg_rdata[N_RAILS-1:0] = pgood;
        reg_rdata[4] = alarm_q;
      end
      A_FAIL: reg_rdata[N_RAILS-1:0] = fail_q;
      default: reg_rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= 8'h00;
      alarm_q <= 1'b0;
      fail_q  <= '0;
    end else begin
      if (ctl_wr) ctrl_q <= reg_wdata;
      if (clr_wr) begin
        alarm_q <= 1'b0;
        fail_q  <= '0;
      end else if (trip) begin
        alarm_q <= 1'b1;
        fail_q  <= trip_vec;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= S_OFF;
      idx <= '0;
      cnt <= '0;
    end else begin
      case (st)
        S_OFF: if (ctrl_en) begin
          st  <= S_RAMP;
          idx <= '0;
          cnt <= '0;
        end
        S_RAMP: begin
          if (!ctrl_en) begin
            st  <= S_DISCH;
            cnt <= '0;
          end else if (trip) begin
            st <= S_FAULT;
          end else if (pgood[idx]) begin
            cnt <= '0;
            if (idx == IW'(N_RAILS - 1)) st <= S_ON;
            else idx <= idx + 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_ON: begin
          if (!ctrl_en) begin
            st  <= S_DISCH;
            cnt <= '0;
          end else if (trip) begin
            st <= S_FAULT;
          end
        end
        S_FAULT: if (!ctrl_en) begin
          st  <= S_DISCH;
          cnt <= '0;
        end
        S_DISCH: begin
          if (cnt == CW'(DISCH_CYCLES - 1)) st <= S_OFF;
          else cnt <= cnt + 1'b1;
        end
        default: st <= S_OFF;
      endcase
    end
  end

  AST_PREFIX_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    (rail_en & (rail_en + 1'b1)) == '0); // R3
  AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RAMP) |-> (cnt < CW'(STEP_CYCLES))); // R4
  AST_ALARM_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_q |-> (rail_en == '0)); // R5
  AST_FAIL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fail_q) && (alarm_q == (fail_q != '0))); // R5
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm_q && !clr_wr) |=> (alarm_q && $stable(fail_q))); // R7
  AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (rail_en == '0)); // R8
  AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_DISCH) && (cnt < CW'(DISCH_CYCLES - 1))) |=> (rail_en == '0)); // R9
endmodule

// File: tb/sim_pwr_seq.sv
module sim_pwr_seq;
  localparam int N = 4;
  localparam int STEP = 12;
  localparam int DISCH = 25;

  logic clk = 0, rst_n = 0;
  logic reg_wr = 0;
  logic [3:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [N-1:0] pgood, rail_en, block = 0, drop = 0;
  logic alarm;
  int cyc = 0, checks = 0, errors = 0, last_wr = 0, mon_err = 0;

  pwr_seq #(.N_RAILS(N), .STEP_CYCLES(STEP), .DISCH_CYCLES(DISCH), .VERSION(8'h03)) u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pgood(pgood),
    .rail_en(rail_en), .alarm(alarm));

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) pgood <= '0;
    else pgood <= rail_en & ~block & ~drop;

  always @(negedge clk)
    if (rst_n && drop == '0)
      for (int i = 1; i < N; i++)
        if (rail_en[i] && !pgood[i-1]) begin
          mon_err++;
          $display("FAIL R3 rail %0d on before prior good: act %b exp prior good", i, pgood);
        end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act 0x%0h exp 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    last_wr = cyc;
    reg_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fresh_on();
    wr(4'h6, 8'h00);
    idle(DISCH + 4);
    wr(4'h6, 8'h01);
    idle(3 * N + 4);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog act hung exp done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int a, n, rise;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    chk(rail_en == 0 && alarm == 0, "R1 outputs", {rail_en, alarm}, 0);
    rd(4'h6, d); chk(d == 8'h00, "R1 control", d, 0);
    rd(4'hA, d); chk(d == 8'h00, "R1 status", d, 0);
    rd(4'hB, d); chk(d == 8'h00, "R1 fail", d, 0);
    rd(4'h0, d); chk(d == 8'h03, "R1 id", d, 3);
    // R2 decode
    rd(4'h3, d); chk(d == 8'h00, "R2 unmapped", d, 0);
    wr(4'hA, 8'hFF);
    rd(4'hA, d); chk(d == 8'h00 && rail_en == 0, "R2 status write ignored", d, 0);
    wr(4'h6, 8'hA5);
    rd(4'h6, d); chk(d == 8'hA5, "R2 control readback", d, 8'hA5);
    // R3 ordered bring-up
    idle(3 * N + 4);
    chk(rail_en == 4'hF, "R3 all on", rail_en, 4'hF);
    rd(4'hA, d); chk(d == 8'h0F, "R3 status good", d, 8'h0F);
    // R8 disable off on write edge, R9 lockout with held enable
    wr(4'h6, 8'h00);
    a = last_wr;
    chk(rail_en == 0, "R8 rails off", rail_en, 0);
    wr(4'h6, 8'h01);
    rise = 0;
    for (int i = 0; i < 200 && rise == 0; i++) begin
      if (rail_en[0]) rise = cyc; else @(negedge clk);
    end
    chk(rise == a + DISCH + 2, "R9 held enable timing", rise - a, DISCH + 2);
    idle(3 * N + 4);
    // R9 enable after lockout
    wr(4'h6, 8'h00);
    idle(DISCH + 6);
    chk(rail_en == 0, "R9 idle off", rail_en, 0);
    wr(4'h6, 8'h01);
    a = last_wr;
    chk(rail_en[0] == 0, "R9 not yet", rail_en, 0);
    @(negedge clk);
    chk(rail_en[0] == 1 && cyc == a + 1, "R9 late enable", cyc - a, 1);
    // R4 step timeout per rail
    for (int r = 0; r < N; r++) begin
      wr(4'h6, 8'h00);
      idle(DISCH + 4);
      block = N'(1) << r;
      wr(4'h6, 8'h01);
      n = 0;
      for (int i = 0; i < 200 && !alarm; i++) begin
        if (rail_en[r]) n++;
        @(negedge clk);
      end
      chk(n == STEP, "R4 step cycles", n, STEP);
      rd(4'hB, d); chk(d == (8'h01 << r), "R4 fail rail", d, 8'h01 << r);
      rd(4'hA, d); chk(d[4] == 1 && rail_en == 0, "R5 alarm rails off", {d[4], rail_en}, 5'h10);
      block = 0;
    end
    // R7 sticky fault
    wr(4'h6, 8'h01);
    idle(10);
    rd(4'hB, d);
    chk(d == 8'h08 && alarm && rail_en == 0, "R7 sticky", {d, alarm, rail_en}, {8'h08, 1'b1, 4'h0});
    wr(4'h6, 8'h00);
    rd(4'hB, d);
    chk(d == 0 && !alarm, "R7 cleared", {d, alarm}, 0);
    // R6 dropout sweep while all on
    for (int m = 1; m < 16; m++) begin
      fresh_on();
      drop = 4'(m);
      idle(3);
      rd(4'hB, d);
      chk(d == 8'(m & -m), "R6 lowest dropout", d, m & -m);
      chk(alarm && rail_en == 0, "R5 dropout shutdown", {alarm, rail_en}, 5'h10);
      drop = 0;
    end
    // R6 earlier rail drops while later rail ramps
    wr(4'h6, 8'h00);
    idle(DISCH + 4);
    block = 4'b0100;
    wr(4'h6, 8'h01);
    for (int i = 0; i < 50 && !rail_en[2]; i++) @(negedge clk);
    idle(2);
    drop = 4'b0001;
    idle(3);
    rd(4'hB, d);
    chk(d == 8'h01 && alarm, "R6 dropout during ramp", d, 1);
    drop = 0; block = 0;
    wr(4'h6, 8'h00);
    idle(2);
    chk(mon_err == 0, "R3 ordering monitor", mon_err, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule